// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the program counter of a simple single-issue processor and picks the address of the next instruction on every rising clock edge. The current counter value goes straight out as the fetch address for an instruction memory. The instruction memory sits outside the block.

Each cycle the block chooses one of three candidates for the next address:

- the sequential address, which is the current address plus 4;
- a PC-relative branch target, built from a signed 16-bit word offset;
- a region-relative jump target, built from a 26-bit word index.

The decoder supplies three controls: a branch-select strobe, the ALU equality (zero) flag and a jump strobe. It also passes the immediate and target fields of the current instruction. A synchronous reset loads a start address, which is a parameter.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `fetch_addr` becomes `RESET_ADDR` on that edge. The default value of `RESET_ADDR` is 0x00000000.
- R2: When `jmp` is low and `br_sel` and `alu_zero` are not both high, the next `fetch_addr` is the current value plus 4.
- R3: When `jmp` is low and both `br_sel` and `alu_zero` are high, the next `fetch_addr` is (current + 4) + (sign-extended `imm` shifted left by two bits). For example, `imm` = 3 advances 16 bytes beyond the current address.
- R4: Either `br_sel` or `alu_zero` alone does not redirect the counter. The next address is the sequential one.
- R5: When `jmp` is high, the next `fetch_addr` is {current bits 31..28, `jtarget`, 2'b00}. This holds whatever `br_sel` and `alu_zero` are.
- R6: Bits 1..0 of `fetch_addr` stay zero at every edge after reset.
- R7: Sequential advance wraps modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R8: A negative `imm` (bit 15 set) moves the counter backwards. For example, `imm` = 0xFFFE gives (current + 4) − 8.
- R9: A jump takes bits 31..28 from the current address and not from the incremented one. A jump issued at 0x0FFFFFFC stays in region 0x0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Current instruction is a conditional branch |
| alu_zero | input | 1 | ALU reports equal operands |
| jmp | input | 1 | Current instruction is a jump |
| imm | input | 16 | Signed branch word offset |
| jtarget | input | 26 | Jump word index within the current 256 MB region |
| fetch_addr | output | 32 | Current program counter, used as the instruction memory address |

## Verification
The bench builds two copies of the block with different parameter values.

- **First copy:** uses the default start address of zero. A table of ten steps drives it through:
  - sequential steps;
  - half-asserted branch conditions;
  - forward branches and backward branches, including the largest positive and most negative offsets;
  - a jump to the last word of region 0;
  - a jump issued while a branch is also asserted.
- **Second copy:** built with a start address of 0xFFFFFFF8. This brings the top of the address space within two cycles of reset, which makes the wraparound of the sequential path observable.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_sel,
  input  logic              alu_zero,
  input  logic              jmp,
  input  logic [IMM_W-1:0]  imm,
  input  logic [TGT_W-1:0]  jtarget,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int REGION_W = ADDR_W - TGT_W - 2;
  localparam int EXT_W    = ADDR_W - IMM_W - 2;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_offset;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] jmp_addr;
  logic [ADDR_W-1:0] next_pc;
  logic              take_br;

  assign seq_addr  = pc_q + ADDR_W'(4);
  assign br_offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  assign br_addr   = seq_addr + br_offset;
  assign jmp_addr  = {pc_q[ADDR_W-1 -: REGION_W], jtarget, 2'b00};
  assign take_br   = br_sel & alu_zero;
  assign next_pc   = jmp ? jmp_addr : (take_br ? br_addr : seq_addr);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_ADDR;
    else     pc_q <= next_pc;
  end

  assign fetch_addr = pc_q;

  a_r1_reset_start: assert property (@(posedge clk)
    rst |=> fetch_addr == RESET_ADDR);

  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !(br_sel && alu_zero)) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));

  a_r3_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (br_sel && alu_zero && !jmp) |=>
      fetch_addr == $past(fetch_addr) + ADDR_W'(4) + ADDR_W'(signed'($past(imm))) * ADDR_W'(4));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    jmp |=> fetch_addr[TGT_W+1:2] == $past(jtarget));

  a_r9_jump_region: assert property (@(posedge clk) disable iff (rst)
    jmp |=> fetch_addr[ADDR_W-1 -: REGION_W] == $past(fetch_addr[ADDR_W-1 -: REGION_W]));

  a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
    fetch_addr[1:0] == 2'b00);
endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_sel = 1'b0;
  logic        alu_zero = 1'b0;
  logic        jmp = 1'b0;
  logic [15:0] imm = '0;
  logic [25:0] jtarget = '0;
  logic [31:0] pc_lo;
  logic [31:0] pc_hi;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // fields: br_sel, alu_zero, jmp, imm, jtarget, expected next address
  localparam logic [76:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0000_0004}, // R2
    {1'b1, 1'b0, 1'b0, 16'h0040, 26'h0000000, 32'h0000_0008}, // R4 branch only
    {1'b0, 1'b1, 1'b0, 16'h0040, 26'h0000000, 32'h0000_000C}, // R4 zero only
    {1'b1, 1'b1, 1'b0, 16'h0003, 26'h0000000, 32'h0000_001C}, // R3
    {1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0000000, 32'h0000_0018}, // R8
    {1'b1, 1'b1, 1'b1, 16'h0005, 26'h3FFFFFF, 32'h0FFF_FFFC}, // R5 priority
    {1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h1000_0000}, // R2 region cross
    {1'b0, 1'b0, 1'b1, 16'h0000, 26'h0000010, 32'h1000_0040}, // R9
    {1'b1, 1'b1, 1'b0, 16'h7FFF, 26'h0000000, 32'h1002_0040}, // R3 max
    {1'b1, 1'b1, 1'b0, 16'h8000, 26'h0000000, 32'h1000_0044}  // R8 min
  };

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .br_sel(br_sel), .alu_zero(alu_zero), .jmp(jmp),
    .imm(imm), .jtarget(jtarget), .fetch_addr(pc_lo)
  );

  pc_sequencer #(.RESET_ADDR(32'hFFFF_FFF8)) i_pc_sequencer_hi (
    .clk(clk), .rst(rst), .br_sel(br_sel), .alu_zero(alu_zero), .jmp(jmp),
    .imm(imm), .jtarget(jtarget), .fetch_addr(pc_hi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    step();
    step();
    rst = 1'b0;
    check("R1 reset low copy", pc_lo, 32'h0000_0000);
    check("R1 reset high copy", pc_hi, 32'hFFFF_FFF8);

    for (int k = 0; k < NVEC; k++) begin
      {br_sel, alu_zero, jmp, imm, jtarget} = VEC[k][76:32];
      step();
      check($sformatf("R2-R9 vector %0d", k), pc_lo, VEC[k][31:0]);
      check("R6 alignment", {30'd0, pc_lo[1:0]}, 32'd0);
    end

    {br_sel, alu_zero, jmp, imm, jtarget} = '0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 mid-run reset", pc_lo, 32'h0000_0000);
    check("R1 mid-run reset high", pc_hi, 32'hFFFF_FFF8);
    step();
    check("R2 high copy", pc_hi, 32'hFFFF_FFFC);
    step();
    check("R7 wraparound", pc_hi, 32'h0000_0000);

    rst = 1'b1;
    step();
    rst = 1'b0;
    jmp = 1'b1;
    jtarget = 26'h0000001;
    step();
    check("R9 jump keeps high region", pc_hi, 32'hF000_0004);
    check("R5 jump low copy", pc_lo, 32'h0000_0004);
    jmp = 1'b0;
    step();
    check("R6 alignment high", {30'd0, pc_hi[1:0]}, 32'd0);
    finish_run();
  end
endmodule